// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

A 32-bit seconds counter that sits on a zero-wait, APB-style register bus. A reference enable input (nominally 32768 Hz, one pulse per cycle of the reference) drives a power-of-two prescaler. Each time the prescaler completes its period, the count advances by one second. Software can set the count through a load register, read the live count, and enable or freeze counting through a control bit.

A match register holds an alarm time. When the count takes on the match value, the alarm status bit is set. A mask bit gates this status onto the interrupt output. Writing a one to the clear register removes the status. Reads of the raw and gated status are offered separately, so that a polling routine and an interrupt routine see the same event.

Register word offsets: 0x00 live count (read only), 0x04 match value, 0x08 load value (reads back the last value written), 0x0C control (bit 0 = run), 0x10 alarm mask (bit 0), 0x14 raw alarm status (bit 0, read only), 0x18 gated alarm status (bit 0, read only), 0x1C alarm clear (bit 0, write one, reads 0).

Top module: `sec_alarm_timer`

## Requirements
- R1: After reset, the count, match, load, control, mask and both status registers read 0, and irq_o is low.
- R2: While control bit 0 is 1 and tick_en_i is high, the count advances by one every 2^PRESCALE_W enabled cycles. While control bit 0 is 0, the count holds its value.
- R3: A write to offset 0x08 replaces the count in the same cycle and restarts the prescaler from zero. Offset 0x08 reads back the value last written there.
- R4: An advance from 0xFFFFFFFF gives 0.
- R5: Status bit 0 at 0x14 becomes 1 in the cycle in which the count is updated, by an advance or by a load, to a value equal to the match register.
- R6: Offset 0x18 bit 0 equals the raw status AND mask bit 0 at 0x10, and irq_o carries the same value.
- R7: Writing 1 to bit 0 of 0x1C clears the raw status, and writing 0 there leaves it unchanged. If a set and a clear fall in the same cycle, the status ends up at 1.
- R8: Reads of unmapped offsets (0x20 and above, or an address whose bits 1:0 are not zero) return 0. Writes to 0x00, 0x14, 0x18 and to unmapped offsets change no state.
- R9: With tick_en_i low, the prescaler and the count do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Reference tick enable, one pulse per reference cycle |
| psel_i | input | 1 | Peripheral select |
| penable_i | input | 1 | Access phase strobe |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | ADDR_W | Byte address |
| pwdata_i | input | DATA_W | Write data |
| prdata_o | output | DATA_W | Read data for the decoded offset |
| irq_o | output | 1 | Gated alarm interrupt |

## Verification
The count is run through four patterns: free advance, a held enable, a held reference tick, and a load near the top of the range. Together they separate a prescaler fault from a counter fault and show whether wrap is correct. The alarm is raised in two ways, by advancing into the match and by loading the match value directly. It is then read with the mask off and with the mask on, which tells the raw path apart from the gated path. A clear is timed onto the exact edge of an advance, which shows which of set and clear has priority. Writes to read-only and unmapped offsets are each followed by a read of the state they could have changed.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [2:0] {
    REG_COUNT = 3'd0,
    REG_MATCH = 3'd1,
    REG_LOAD  = 3'd2,
    REG_CTRL  = 3'd3,
    REG_MASK  = 3'd4,
    REG_RAW   = 3'd5,
    REG_MSTAT = 3'd6,
    REG_CLEAR = 3'd7
  } reg_idx_e;

  localparam int unsigned IDX_LSB = 2;
  localparam int unsigned IDX_W   = 3;
endpackage

// File: rtl/sat_prescaler.sv
module sat_prescaler #(
  parameter int unsigned WIDTH = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic adv_o
);
  localparam logic [WIDTH-1:0] LAST = '1;
  logic [WIDTH-1:0] cnt_q;

  assign adv_o = run_i && !restart_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= cnt_q + {{(WIDTH-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic [WIDTH-1:0] count_o,
  output logic [WIDTH-1:0] next_o,
  output logic             upd_o
);
  logic [WIDTH-1:0] count_q;

  assign upd_o = adv_i | load_i;

  always_comb begin
    next_o = count_q;
    if (load_i)     next_o = load_val_i;
    else if (adv_i) next_o = count_q + {{(WIDTH-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    count_q <= '0;
    else if (upd_o) count_q <= next_o;
  end

  assign count_o = count_q;
endmodule

// File: rtl/sat_alarm.sv
module sat_alarm #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [WIDTH-1:0] next_i,
  input  logic [WIDTH-1:0] match_i,
  input  logic             mask_i,
  input  logic             clr_i,
  output logic             raw_o,
  output logic             set_o,
  output logic             irq_o
);
  logic raw_q;

  // only an update of the count arms the alarm, not a match write
  assign set_o = upd_i && (next_i == match_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= 1'b0;
    else         raw_q <= set_o | (raw_q & ~clr_i);
  end

  assign raw_o = raw_q;
  assign irq_o = raw_q & mask_i;
endmodule

// File: rtl/sec_alarm_timer.sv
module sec_alarm_timer
  import sat_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned PRESCALE_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              irq_o
);
  localparam int unsigned DEC_MSB = IDX_LSB + IDX_W;

  logic              mapped, wr;
  reg_idx_e          idx;
  logic              load_wr, clr_wr;
  logic [DATA_W-1:0] match_q, load_q;
  logic              en_q, mask_q;
  logic              adv, upd, raw, alarm_set;
  logic [DATA_W-1:0] count, count_nxt;

  assign mapped  = (paddr_i[ADDR_W-1:DEC_MSB] == '0) && (paddr_i[IDX_LSB-1:0] == '0);
  assign idx     = reg_idx_e'(paddr_i[DEC_MSB-1:IDX_LSB]);
  assign wr      = psel_i && penable_i && pwrite_i && mapped;
  assign load_wr = wr && (idx == REG_LOAD);
  assign clr_wr  = wr && (idx == REG_CLEAR) && pwdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '0;
      load_q  <= '0;
      en_q    <= 1'b0;
      mask_q  <= 1'b0;
    end else if (wr) begin
      case (idx)
        REG_MATCH: match_q <= pwdata_i;
        REG_LOAD:  load_q  <= pwdata_i;
        REG_CTRL:  en_q    <= pwdata_i[0];
        REG_MASK:  mask_q  <= pwdata_i[0];
        default: ;
      endcase
    end
  end

  sat_prescaler #(.WIDTH(PRESCALE_W)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (en_q & tick_en_i),
    .restart_i (load_wr),
    .adv_o     (adv)
  );

  sat_counter #(.WIDTH(DATA_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .load_i     (load_wr),
    .load_val_i (pwdata_i),
    .count_o    (count),
    .next_o     (count_nxt),
    .upd_o      (upd)
  );

  sat_alarm #(.WIDTH(DATA_W)) u_alarm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (upd),
    .next_i  (count_nxt),
    .match_i (match_q),
    .mask_i  (mask_q),
    .clr_i   (clr_wr),
    .raw_o   (raw),
    .set_o   (alarm_set),
    .irq_o   (irq_o)
  );

  always_comb begin
    prdata_o = '0;
    if (mapped) begin
      unique case (idx)
        REG_COUNT: prdata_o = count;
        REG_MATCH: prdata_o = match_q;
        REG_LOAD:  prdata_o = load_q;
        REG_CTRL:  prdata_o[0] = en_q;
        REG_MASK:  prdata_o[0] = mask_q;
        REG_RAW:   prdata_o[0] = raw;
        REG_MSTAT: prdata_o[0] = irq_o;
        REG_CLEAR: prdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/sec_alarm_timer_chk.sv
module sec_alarm_timer_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_wr_i,
  input logic              clr_wr_i,
  input logic [DATA_W-1:0] pwdata_i,
  input logic              en_i,
  input logic              adv_i,
  input logic              set_i,
  input logic [DATA_W-1:0] count_i,
  input logic [DATA_W-1:0] match_i,
  input logic              raw_i,
  input logic              mask_i,
  input logic              irq_i
);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_wr_i) |=> $stable(count_i));

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_wr_i) |=> (count_i == $past(count_i) + 1));

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_wr_i |=> (count_i == $past(pwdata_i)));

  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_wr_i && (count_i == '1)) |=> (count_i == '0));

  p_raw_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_i) |-> (count_i == $past(match_i)));

  p_irq_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (raw_i && mask_i));

  p_irq_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i && mask_i) |-> irq_i);

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && !set_i) |=> !raw_i);

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> raw_i);
endmodule

bind sec_alarm_timer sec_alarm_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_wr_i (load_wr),
  .clr_wr_i  (clr_wr),
  .pwdata_i  (pwdata_i),
  .en_i      (en_q),
  .adv_i     (adv),
  .set_i     (alarm_set),
  .count_i   (count),
  .match_i   (match_q),
  .raw_i     (raw),
  .mask_i    (mask_q),
  .irq_i     (irq_o)
);

// File: tb/test_sec_alarm_timer.sv
module test_sec_alarm_timer;
  localparam int PW   = 4;
  localparam int PMAX = (1 << PW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sec_alarm_timer #(.ADDR_W(12), .DATA_W(32), .PRESCALE_W(PW)) i_sec_alarm_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .irq_o(irq)
  );

  // behavioural reference model
  logic [31:0] m_count, m_match, m_load, m_nxt;
  logic        m_en, m_mask, m_raw, m_wr, m_upd, m_set, m_clr;
  int          m_pre, m_idx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_count = 0; m_match = 0; m_load = 0;
      m_en = 0; m_mask = 0; m_raw = 0; m_pre = 0;
    end else begin
      m_wr  = psel && penable && pwrite && (paddr[11:5] == 0) && (paddr[1:0] == 0);
      m_idx = int'(paddr[4:2]);
      m_upd = 0;
      m_nxt = m_count;
      if (m_wr && m_idx == 2) begin
        m_nxt = pwdata; m_upd = 1; m_pre = 0;
      end else if (m_en && tick_en) begin
        if (m_pre == PMAX) begin m_pre = 0; m_nxt = m_count + 1; m_upd = 1; end
        else m_pre = m_pre + 1;
      end
      m_set = m_upd && (m_nxt == m_match);
      m_clr = m_wr && m_idx == 7 && pwdata[0];
      m_raw = m_set | (m_raw & ~m_clr);
      m_count = m_nxt;
      if (m_wr) begin
        case (m_idx)
          1: m_match = pwdata;
          2: m_load  = pwdata;
          3: m_en    = pwdata[0];
          4: m_mask  = pwdata[0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    if (a[11:5] != 0 || a[1:0] != 0) return 32'h0;
    case (a[4:2])
      3'd0: return m_count;
      3'd1: return m_match;
      3'd2: return m_load;
      3'd3: return {31'b0, m_en};
      3'd4: return {31'b0, m_mask};
      3'd5: return {31'b0, m_raw};
      3'd6: return {31'b0, m_raw & m_mask};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison of the interrupt line (R6)
  always @(negedge clk)
    if (rst_n && !done) chk("R6 irq_o vs model", {31'b0, irq}, {31'b0, m_raw & m_mask});

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk) penable = 1;
    @(negedge clk) begin psel = 0; penable = 0; pwrite = 0; end
  endtask

  task automatic rd(input logic [11:0] a, input string tag, output logic [31:0] v);
    psel = 1; pwrite = 0; paddr = a;
    @(negedge clk) penable = 1;
    #1 v = prdata;
    chk(tag, v, exp_rd(a));
    @(negedge clk) begin psel = 0; penable = 0; end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, v1, v2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(12'(i * 4), "R1 reset read", v);
      chk("R1 reset value", v, 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R3 load, readback
    wr(12'h00C, 32'h1);
    wr(12'h008, 32'd100);
    rd(12'h000, "R3 count after load", v);
    chk("R3 count equals load", v, 32'd100);
    rd(12'h008, "R3 load readback", v);
    chk("R3 load readback value", v, 32'd100);

    // R2 advance and hold
    idle(40);
    rd(12'h000, "R2 count advancing", v);
    chk("R2 count moved", {31'b0, v > 32'd100}, 32'h1);
    wr(12'h00C, 32'h0);
    rd(12'h000, "R2 count before hold", v1);
    idle(50);
    rd(12'h000, "R2 count during hold", v2);
    chk("R2 held count", v2, v1);

    // R9 tick enable low
    wr(12'h00C, 32'h1);
    tick_en = 0;
    rd(12'h000, "R9 count before", v1);
    idle(50);
    rd(12'h000, "R9 count after", v2);
    chk("R9 no advance without tick", v2, v1);
    tick_en = 1;

    // R4 wrap
    wr(12'h008, 32'hFFFF_FFFF);
    idle(18);
    rd(12'h000, "R4 wrap read", v);
    chk("R4 wrapped to zero", v, 32'h0);

    // R5/R6 alarm by advance, mask off then on
    wr(12'h010, 32'h0);
    wr(12'h004, 32'd5);
    wr(12'h008, 32'd4);
    idle(20);
    rd(12'h014, "R5 raw after advance", v);
    chk("R5 raw set by advance", v, 32'h1);
    rd(12'h018, "R6 masked with mask off", v);
    chk("R6 masked status off", v, 32'h0);
    chk("R6 irq low with mask off", {31'b0, irq}, 32'h0);
    wr(12'h010, 32'h1);
    rd(12'h018, "R6 masked with mask on", v);
    chk("R6 masked status on", v, 32'h1);
    chk("R6 irq high with mask on", {31'b0, irq}, 32'h1);

    // R7 clear behaviour
    wr(12'h01C, 32'h0);
    rd(12'h014, "R7 raw after zero write", v);
    chk("R7 zero write keeps status", v, 32'h1);
    wr(12'h01C, 32'h1);
    rd(12'h014, "R7 raw after clear", v);
    chk("R7 clear removes status", v, 32'h0);
    chk("R7 irq low after clear", {31'b0, irq}, 32'h0);

    // R5 alarm by load
    wr(12'h00C, 32'h0);
    wr(12'h008, 32'd5);
    rd(12'h014, "R5 raw after load", v);
    chk("R5 raw set by load", v, 32'h1);
    wr(12'h01C, 32'h1);
    wr(12'h008, 32'd6);
    rd(12'h014, "R5 raw after non-matching load", v);
    chk("R5 no set on mismatch", v, 32'h0);

    // R7 set wins over clear in the same cycle
    wr(12'h00C, 32'h1);
    wr(12'h004, 32'd10);
    wr(12'h008, 32'd9);
    wr(12'h01C, 32'h1);
    while (m_pre != PMAX - 1) @(negedge clk);
    wr(12'h01C, 32'h1);
    rd(12'h014, "R7 raw after collision", v);
    chk("R7 set wins", v, 32'h1);
    rd(12'h000, "R7 count at collision", v);
    chk("R7 count reached match", v, 32'd10);

    // R8 read-only and unmapped
    wr(12'h00C, 32'h0);
    rd(12'h000, "R8 count before write", v1);
    wr(12'h000, 32'hDEAD_BEEF);
    rd(12'h000, "R8 count after write", v2);
    chk("R8 count write ignored", v2, v1);
    wr(12'h01C, 32'h1);
    wr(12'h014, 32'h1);
    rd(12'h014, "R8 raw after write", v);
    chk("R8 raw write ignored", v, 32'h0);
    wr(12'h018, 32'h1);
    rd(12'h018, "R8 masked after write", v);
    chk("R8 masked write ignored", v, 32'h0);
    wr(12'h024, 32'd77);
    rd(12'h004, "R8 match after unmapped write", v);
    chk("R8 unmapped write no alias", v, 32'd10);
    rd(12'h020, "R8 unmapped 0x20", v);
    chk("R8 unmapped reads zero", v, 32'h0);
    rd(12'h7FC, "R8 unmapped high", v);
    chk("R8 high unmapped reads zero", v, 32'h0);
    rd(12'h005, "R8 misaligned", v);
    chk("R8 misaligned reads zero", v, 32'h0);
    rd(12'h01C, "R8 clear reads", v);
    chk("R8 clear reads zero", v, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule